// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block collects three interrupt causes into a single byte of pending flags and enables and drives one request line toward the processor core.

The three causes are:
- an edge on port bit 0, with the edge direction chosen by software;
- a one-cycle overflow strobe from an 8-bit timer;
- any difference between the upper nibble of the port and a reference value.

The reference value is refreshed whenever software reads the port.

Software reaches the block through a simple register port with a one-bit address. Address 0 holds the flag/enable byte and address 1 holds the edge-select bit. Each flag is raised by its event regardless of whether that source is enabled. A flag stays set until software writes 0 to it. The request line is the global enable gating the OR of the enabled, pending flags.

All port pins pass through a two-stage synchronizer before any edge or change detection. The synchronized port value is also brought out so the core can read it, and that read is what refreshes the change reference.

Top module: `irq_gather`

## Requirements
- R1: After reset, the byte at address 0, the edge-select bit at address 1, `irq` and the change reference are all 0.
- R2: The byte at address 0 is laid out as follows: bit 0 port-change flag, bit 1 external-pin flag, bit 2 timer flag, bit 3 port-change enable, bit 4 external-pin enable, bit 5 timer enable, bit 7 global enable. A write at address 0 loads all of these bits.
- R3: Address 1 bit 0 selects the external edge: 0 means falling and 1 means rising. The external flag is set on the third rising clock edge after the qualifying change of `pin_in[0]`.
- R4: The port-change flag is set while the synchronized `pin_in[7:4]` differs from the reference. A change on `pin_in[3:0]` alone never sets it.
- R5: `port_val` is `pin_in` delayed by two clock edges. A cycle with `port_rd` high loads the reference with the current `port_val[7:4]`.
- R6: A cycle with `tmr_ovf` high sets the timer flag at that clock edge.
- R7: Flags are set whatever their enables are. `irq` is high exactly when bit 7 is 1 and some flag has its matching enable set.
- R8: A flag only falls when software writes 0 to it at address 0. Writing 1 sets it. A hardware set in the same cycle as a software clear leaves the flag set.
- R9: Bit 6 of address 0 always reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 flags/enables, 1 edge select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| port_rd | input | 1 | Port read strobe; refreshes the change reference |
| port_val | output | 8 | Synchronized port value |
| pin_in | input | 8 | Raw port pins |
| tmr_ovf | input | 1 | Timer overflow strobe |
| irq | output | 1 | Interrupt request to the core |

## Verification
The external pin is tested with both edge selections, so that a swapped polarity or a missing edge-register stage shows up. The port is tested first with changes confined to the low nibble, then with changes in the high nibble. Clears are issued both before and after a port read, which separates reference handling from flag handling. Timer strobes are lined up in the same cycle as clears of that flag, exposing the priority between hardware set and software clear. A long stretch of random writes, pins and strobes is then compared every cycle against the bench's behavioural model, covering flag/enable combinations and the gating of `irq`.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CHG_LSB     = 4,
  parameter int EXT_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              port_rd,
  output logic [PORT_W-1:0] port_val,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              tmr_ovf,
  output logic              irq
);

  localparam int CHG_W = PORT_W - CHG_LSB;

  logic [PORT_W-1:0] sync_q [SYNC_STAGES];
  logic              ext_prev;
  logic [CHG_W-1:0]  chg_ref;
  logic              edge_sel;
  logic [2:0]        flags;
  logic [2:0]        ens;
  logic              gie;
  logic [7:0]        stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign port_val = sync_q[SYNC_STAGES-1];

  wire ext_now = port_val[EXT_BIT];
  wire ext_hit = edge_sel ? (ext_now & ~ext_prev) : (~ext_now & ext_prev);
  wire chg_hit = port_val[PORT_W-1:CHG_LSB] != chg_ref;
  wire [2:0] hw_set = {tmr_ovf, ext_hit, chg_hit};
  wire wr_stat = wr_en & ~addr;
  wire wr_sel  = wr_en & addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      chg_ref  <= '0;
      edge_sel <= 1'b0;
      flags    <= '0;
      ens      <= '0;
      gie      <= 1'b0;
    end else begin
      ext_prev <= ext_now;
      if (port_rd) chg_ref <= port_val[PORT_W-1:CHG_LSB];
      if (wr_sel) edge_sel <= wdata[0];
      if (wr_stat) begin
        flags <= wdata[2:0] | hw_set;
        ens   <= wdata[5:3];
        gie   <= wdata[7];
      end else begin
        flags <= flags | hw_set;
      end
    end
  end

  assign stat  = {gie, 1'b0, ens, flags};
  assign rdata = addr ? {7'b0, edge_sel} : stat;
  assign irq   = gie & |(flags & ens);

endmodule

module irq_gather_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       tmr_ovf,
  input logic       irq,
  input logic [7:0] stat
);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat[7]);

  assert_tmr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> stat[2]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && wr_en && !addr && !wdata[2]) |=> stat[2]);

  assert_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[1]) |-> $past(wr_en && !addr));

  assert_bit6_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> !rdata[6]);

endmodule

bind irq_gather irq_gather_chk u_chk (.*);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0, port_rd = 0, tmr_ovf = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, port_val;
  logic irq;
  int checks = 0, errors = 0;

  irq_gather u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .port_rd(port_rd), .port_val(port_val), .pin_in(pin_in),
    .tmr_ovf(tmr_ovf), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference: pin history, reference nibble, register contents
  logic [7:0] h0 = 0, h1 = 0, h2 = 0;
  logic [3:0] m_ref = 0;
  logic m_sel = 0, m_gie = 0;
  logic [2:0] m_flag = 0, m_en = 0;

  always @(posedge clk) begin
    logic ext_ev, chg_ev;
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_ref = 0; m_sel = 0; m_gie = 0; m_flag = 0; m_en = 0;
    end else begin
      ext_ev = m_sel ? (h1[0] && !h2[0]) : (!h1[0] && h2[0]);
      chg_ev = (h1[7:4] != m_ref);
      if (port_rd) m_ref = h1[7:4];
      if (wr_en && addr) m_sel = wdata[0];
      if (wr_en && !addr) begin
        m_flag = wdata[2:0]; m_en = wdata[5:3]; m_gie = wdata[7];
      end
      if (tmr_ovf) m_flag[2] = 1;
      if (ext_ev)  m_flag[1] = 1;
      if (chg_ev)  m_flag[0] = 1;
      h2 = h1; h1 = h0; h0 = pin_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (addr) chk("R3 edge select readback", rdata, {7'b0, m_sel});
    else begin
      chk("R4 port-change flag", rdata[0], m_flag[0]);
      chk("R3 external flag", rdata[1], m_flag[1]);
      chk("R6 timer flag", rdata[2], m_flag[2]);
      chk("R2 enables and global", {rdata[7], rdata[5:3]}, {m_gie, m_en});
      chk("R9 bit6 reads zero", rdata[6], 0);
    end
    chk("R7 irq", irq, m_gie & |(m_flag & m_en));
    chk("R5 port_val", port_val, h1);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0; addr = 0;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    addr = 0; #1; chk("R1 reset byte", rdata, 0); chk("R1 reset irq", irq, 0);
    addr = 1; #1; chk("R1 reset edge select", rdata, 0); addr = 0;

    wr(0, 8'hFF); chk("R9 write ignores bit6", rdata, 8'hBF);
    chk("R8 write one sets flags", rdata[2:0], 3'b111);
    wr(0, 8'h00); chk("R8 write zero clears", rdata, 0);

    tmr_ovf = 1; tick(); tmr_ovf = 0;
    chk("R6 timer flag set", rdata[2], 1); chk("R7 flag without enable no irq", irq, 0);
    wr(0, 8'hA4); chk("R7 enabled irq", irq, 1);
    wr(0, 8'h24); chk("R7 global gate off", irq, 0);
    wr(0, 8'hA0); chk("R8 cleared", rdata[2], 0);
    addr = 0; wdata = 8'hA0; wr_en = 1; tmr_ovf = 1; tick(); wr_en = 0; tmr_ovf = 0;
    chk("R8 set wins over clear", rdata[2], 1);
    wr(0, 8'h00);

    pin_in[0] = 1; tick(4); chk("R3 rising ignored when falling selected", rdata[1], 0);
    pin_in[0] = 0; tick(2); chk("R3 not before third edge", rdata[1], 0);
    tick(); chk("R3 falling edge flag", rdata[1], 1);
    wr(0, 8'h00); wr(1, 8'h01); addr = 0;
    tick(4); chk("R3 no edge no flag", rdata[1], 0);
    pin_in[0] = 1; tick(3); chk("R3 rising edge flag", rdata[1], 1);
    wr(0, 8'h00);

    pin_in[3:1] = 3'b101; tick(5); chk("R4 low nibble ignored", rdata[0], 0);
    pin_in[6] = 1; tick(3); chk("R4 high nibble change flag", rdata[0], 1);
    wr(0, 8'h00); chk("R4 mismatch keeps setting", rdata[0], 1);
    port_rd = 1; tick(); port_rd = 0; wr(0, 8'h00); tick();
    chk("R5 reference refreshed by read", rdata[0], 0);

    for (int i = 0; i < 2000; i++) begin
      pin_in  = $urandom;
      tmr_ovf = ($urandom % 7) == 0;
      port_rd = ($urandom % 3) == 0;
      wr_en   = ($urandom % 4) == 0;
      addr    = ($urandom % 5) == 0;
      wdata   = $urandom;
      tick();
    end
    wr_en = 0; tmr_ovf = 0; port_rd = 0; tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule